// File: doc/BRIEF.md
# Receive Filter Address Table Port

This block sits beside a receive MAC and holds the storage a frame filter consults: a six-byte station address used for exact destination matching, and a 64-byte multicast hash table. Software reaches both through one indirect window. A 32-bit control register carries a 10-bit window address and the class enable bits. A 16-bit data port then writes or reads the byte pair at that address. Station words live at the bottom of the address space and the hash table sits at a base of 0x200. Malformed accesses raise one-cycle error pulses instead of touching storage.

The same control register steers the per-frame decision. For each frame the MAC presents its 48-bit destination and an ARP marker. One cycle later the block reports whether the frame is accepted. A frame is accepted when the filter is enabled and at least one enabled class matches it. The hash table is stored for software but is not consulted by the decision: with multicast hashing enabled, every multicast frame passes.

Top module: `rx_filter_table_port`

## Requirements
- R1: After a synchronous reset the control register is zero (filter disabled, every accept bit clear), all six station bytes read as zero, and `dec_valid`, `rd_valid`, `err_unaligned`, `err_range` and `err_unsupported` are low.
- R2: Window addresses 0x000, 0x002 and 0x004 select station byte pairs 0/1, 2/3 and 4/5. The lower-numbered byte is in data bits 7:0 and the higher-numbered byte in bits 15:8. A read returns the same pairing as a write.
- R3: An even window address A in 0x200..0x23F writes or reads hash bytes A-0x200 (data bits 7:0) and A-0x200+1 (data bits 15:8).
- R4: An odd window address in 0x200..0x23F raises `err_unaligned` for one cycle, leaves storage unchanged, and on a read returns `rd_data` = 0.
- R5: Any other window address (odd below 0x006, 0x006..0x1FF, 0x240 and above) raises `err_range` for one cycle, modifies nothing, and reads as 0.
- R6: While control bit 31 (filter enable) is 0, every frame is dropped (`dec_accept` = 0).
- R7: Control bit 28 accepts broadcast frames (destination all ones), bit 27 accepts multicast frames (destination bit 0 set, not broadcast), and bit 26 accepts the remaining unicast frames.
- R8: Control bit 25 accepts a frame whose destination equals the station address in all six bytes, where destination bits 7:0 compare with station byte 0 and bits 47:40 with byte 5.
- R9: Control bit 24 accepts frames that arrive with `frm_arp` high.
- R10: Control bit 16 (multicast hash enable) accepts every multicast frame without consulting the hash table.
- R11: `err_unsupported` is high while control bit 17 (unicast hash) or bit 18 (unicast match mode) is set.
- R12: `dec_valid`/`dec_accept` appear one cycle after `frm_valid`, and `rd_valid`/`rd_data` one cycle after `dat_re`. When `dat_we` and `dat_re` are high together the write is performed and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Load the control register |
| ctl_wdata | input | 32 | Control value: window address in 9:0, enables in 31:16 |
| dat_we | input | 1 | Write `dat_wdata` at the window address |
| dat_re | input | 1 | Read the window address |
| dat_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read result present |
| err_unaligned | output | 1 | Pulse: odd address inside the hash range |
| err_range | output | 1 | Pulse: address outside both regions |
| err_unsupported | output | 1 | Unsupported mode bit set in control |
| frm_valid | input | 1 | Frame destination presented |
| frm_dst | input | 48 | Destination address, first byte in bits 7:0 |
| frm_arp | input | 1 | Frame is ARP |
| dec_valid | output | 1 | Decision present |
| dec_accept | output | 1 | 1 = accept, 0 = drop |

## Verification
The bench aims at the edges of the address map: the last station word at 0x004 against its odd neighbours and 0x006, and the last hash word at 0x23E against 0x240. A wrong range compare would write into the wrong store or miss a legal word. Odd hash addresses are written and then the even word is read back. A design that ignored alignment would corrupt that word or return live data. Byte order is checked on both stores and on the exact-match compare, where a swapped byte would reject the station's own address. Each accept class is enabled alone against all three frame kinds, so an enable wired to the wrong class lets the wrong frames through. The disabled filter is tested with every other enable set, and one case drives a simultaneous write and read.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // Fixed control-word layout; the accept logic and software both decode it.
  localparam int CTL_W      = 32;
  localparam int B_FILT_EN  = 31;
  localparam int B_BCAST    = 28;
  localparam int B_MCAST    = 27;
  localparam int B_UCAST    = 26;
  localparam int B_PERFECT  = 25;
  localparam int B_ARP      = 24;
  localparam int B_ULM      = 18;
  localparam int B_UHASH    = 17;
  localparam int B_MHASH    = 16;

  typedef enum logic [1:0] {
    RGN_NONE    = 2'd0,
    RGN_STATION = 2'd1,
    RGN_HASH    = 2'd2
  } rxf_region_e;

  typedef struct packed {
    logic filt_en;
    logic acc_bcast;
    logic acc_mcast;
    logic acc_ucast;
    logic acc_perfect;
    logic acc_arp;
    logic mhash_en;
    logic uhash_en;
    logic ulm_en;
  } rxf_enables_t;

  function automatic rxf_enables_t unpack_enables(input logic [CTL_W-1:0] w);
    rxf_enables_t e;
    e.filt_en     = w[B_FILT_EN];
    e.acc_bcast   = w[B_BCAST];
    e.acc_mcast   = w[B_MCAST];
    e.acc_ucast   = w[B_UCAST];
    e.acc_perfect = w[B_PERFECT];
    e.acc_arp     = w[B_ARP];
    e.mhash_en    = w[B_MHASH];
    e.uhash_en    = w[B_UHASH];
    e.ulm_en      = w[B_ULM];
    return e;
  endfunction
endpackage

// File: rtl/rxf_addr_decode.sv
module rxf_addr_decode
  import rxf_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int ST_WORDS   = 3,
  parameter int HASH_BASE  = 'h200,
  parameter int HASH_BYTES = 64,
  localparam int HW_W      = $clog2(HASH_BYTES / 2),
  localparam int SI_W      = $clog2(ST_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output rxf_region_e       region,
  output logic [SI_W-1:0]   st_idx,
  output logic [HW_W-1:0]   hash_word,
  output logic              unaligned,
  output logic              bad
);
  logic [ADDR_W-1:0] off;
  logic              in_hash;
  logic              in_station;

  always_comb begin
    off        = addr - ADDR_W'(HASH_BASE);
    in_hash    = (32'(addr) >= HASH_BASE) && (32'(addr) < HASH_BASE + HASH_BYTES);
    in_station = (32'(addr) < 2 * ST_WORDS) && !addr[0];
    st_idx     = addr[SI_W:1];
    hash_word  = off[HW_W:1];
    unaligned  = in_hash && addr[0];
    bad        = !in_hash && !in_station;
    if (in_station)                region = RGN_STATION;
    else if (in_hash && !addr[0])  region = RGN_HASH;
    else                           region = RGN_NONE;
  end
endmodule

// File: rtl/rxf_hash_ram.sv
module rxf_hash_ram #(
  parameter int WORDS  = 32,
  parameter int DATA_W = 16,
  localparam int A_W   = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [A_W-1:0]    addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  // Single-port RAM with registered read, no reset: maps onto block RAM.
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/rxf_station_regs.sv
module rxf_station_regs #(
  parameter int ST_WORDS = 3,
  parameter int DATA_W   = 16,
  localparam int SI_W    = $clog2(ST_WORDS),
  localparam int FLAT_W  = ST_WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [SI_W-1:0]   idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q,
  output logic [FLAT_W-1:0] station
);
  logic [DATA_W-1:0] words [ST_WORDS];

  // Word k holds byte 2k in its low half, so the flat vector has byte 0 at bits 7:0.
  for (genvar k = 0; k < ST_WORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                           words[k] <= '0;
      else if (we && idx == SI_W'(k))    words[k] <= wdata;
    end
    assign station[k*DATA_W +: DATA_W] = words[k];
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= words[idx];
  end

  // R5/R4: the station bytes change only on a decoded station write
  p_station_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(station));
endmodule

// File: rtl/rxf_accept.sv
module rxf_accept
  import rxf_pkg::*;
#(
  parameter int MAC_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  rxf_enables_t     en,
  input  logic [MAC_W-1:0] station,
  input  logic             frm_valid,
  input  logic [MAC_W-1:0] frm_dst,
  input  logic             frm_arp,
  output logic             dec_valid,
  output logic             dec_accept
);
  logic is_bcast, is_mcast, is_ucast, is_match, hit;

  always_comb begin
    is_bcast = &frm_dst;
    is_mcast = frm_dst[0] && !is_bcast;
    is_ucast = !frm_dst[0];
    is_match = (frm_dst == station);
    hit = (is_bcast && en.acc_bcast)
        || (is_mcast && (en.acc_mcast || en.mhash_en))
        || (is_ucast && en.acc_ucast)
        || (is_match && en.acc_perfect)
        || (frm_arp  && en.acc_arp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= frm_valid;
      dec_accept <= frm_valid && en.filt_en && hit;
    end
  end

  // R6: no frame is accepted unless the filter was enabled when it arrived
  p_drop_when_off_r6: assert property (@(posedge clk) disable iff (rst)
    dec_accept |-> ($past(en.filt_en) && dec_valid));
endmodule

// File: rtl/rx_filter_table_port.sv
module rx_filter_table_port
  import rxf_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 16,
  parameter int MAC_W      = 48,
  parameter int HASH_BASE  = 'h200,
  parameter int HASH_BYTES = 64,
  localparam int ST_WORDS  = MAC_W / DATA_W,
  localparam int HWORDS    = HASH_BYTES / 2,
  localparam int HW_W      = $clog2(HWORDS),
  localparam int SI_W      = $clog2(ST_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              dat_we,
  input  logic              dat_re,
  input  logic [DATA_W-1:0] dat_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              err_unaligned,
  output logic              err_range,
  output logic              err_unsupported,
  input  logic              frm_valid,
  input  logic [MAC_W-1:0]  frm_dst,
  input  logic              frm_arp,
  output logic              dec_valid,
  output logic              dec_accept
);
  logic [CTL_W-1:0]  ctl_q;
  rxf_enables_t      en;
  rxf_region_e       region, rsel;
  logic [SI_W-1:0]   st_idx;
  logic [HW_W-1:0]   hash_word;
  logic              unaligned, bad;
  logic              acc, rd;
  logic [DATA_W-1:0] st_q, ram_q;
  logic [MAC_W-1:0]  station;

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_wdata;
  end

  assign en  = unpack_enables(ctl_q);
  assign acc = dat_we || dat_re;
  assign rd  = dat_re && !dat_we;

  rxf_addr_decode #(
    .ADDR_W(ADDR_W), .ST_WORDS(ST_WORDS),
    .HASH_BASE(HASH_BASE), .HASH_BYTES(HASH_BYTES)
  ) u_dec (
    .addr(ctl_q[ADDR_W-1:0]), .region(region), .st_idx(st_idx),
    .hash_word(hash_word), .unaligned(unaligned), .bad(bad)
  );

  rxf_station_regs #(.ST_WORDS(ST_WORDS), .DATA_W(DATA_W)) u_st (
    .clk(clk), .rst(rst),
    .we(dat_we && region == RGN_STATION),
    .re(rd && region == RGN_STATION),
    .idx(st_idx), .wdata(dat_wdata), .q(st_q), .station(station)
  );

  rxf_hash_ram #(.WORDS(HWORDS), .DATA_W(DATA_W)) u_ram (
    .clk(clk),
    .we(dat_we && region == RGN_HASH),
    .re(rd && region == RGN_HASH),
    .addr(hash_word), .wdata(dat_wdata), .q(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid      <= 1'b0;
      rsel          <= RGN_NONE;
      err_unaligned <= 1'b0;
      err_range     <= 1'b0;
    end else begin
      rd_valid      <= rd;
      rsel          <= rd ? region : RGN_NONE;
      err_unaligned <= acc && unaligned;
      err_range     <= acc && bad;
    end
  end

  always_comb begin
    case (rsel)
      RGN_STATION: rd_data = st_q;
      RGN_HASH:    rd_data = ram_q;
      default:     rd_data = '0;
    endcase
  end

  assign err_unsupported = en.uhash_en || en.ulm_en;

  rxf_accept #(.MAC_W(MAC_W)) u_acc (
    .clk(clk), .rst(rst), .en(en), .station(station),
    .frm_valid(frm_valid), .frm_dst(frm_dst), .frm_arp(frm_arp),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  // R12: a read result follows exactly one cycle after a read with no write
  p_read_latency_r12: assert property (@(posedge clk) disable iff (rst)
    rd_valid == $past(dat_re && !dat_we));
  // R11: loading an unsupported mode bit is flagged on the next cycle
  p_unsupported_r11: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && (ctl_wdata[B_UHASH] || ctl_wdata[B_ULM])) |=> err_unsupported);
  // R4: alignment errors only follow an access
  p_unaligned_src_r4: assert property (@(posedge clk) disable iff (rst)
    err_unaligned |-> $past(dat_we || dat_re));
  // R5: an address cannot be both misaligned and out of range
  p_err_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(err_unaligned && err_range));
  // R12: decision follows one cycle after a presented frame
  p_dec_latency_r12: assert property (@(posedge clk) disable iff (rst)
    dec_valid == $past(frm_valid));
endmodule

// File: tb/tb_rx_filter_table_port.sv
module tb_rx_filter_table_port;
  localparam logic [31:0] F_EN = 32'h8000_0000, F_BC = 32'h1000_0000,
    F_MC = 32'h0800_0000, F_UC = 32'h0400_0000, F_PM = 32'h0200_0000,
    F_ARP = 32'h0100_0000, F_ULM = 32'h0004_0000, F_UH = 32'h0002_0000,
    F_MH = 32'h0001_0000;

  logic clk = 0, rst = 1;
  logic ctl_we = 0, dat_we = 0, dat_re = 0, frm_valid = 0, frm_arp = 0;
  logic [31:0] ctl_wdata = 0;
  logic [15:0] dat_wdata = 0, rd_data;
  logic [47:0] frm_dst = 0;
  logic rd_valid, err_unaligned, err_range, err_unsupported, dec_valid, dec_accept;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] hmodel [64];

  always #2 clk = ~clk;

  rx_filter_table_port dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_ctl(logic [31:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic wr(logic [9:0] a, logic [15:0] d, output logic ua, output logic rg);
    set_ctl({22'b0, a});
    @(negedge clk); dat_we = 1; dat_wdata = d;
    @(negedge clk); dat_we = 0; ua = err_unaligned; rg = err_range;
  endtask

  task automatic rdw(logic [9:0] a, output logic [15:0] d, output logic v,
                     output logic ua, output logic rg);
    set_ctl({22'b0, a});
    @(negedge clk); dat_re = 1;
    @(negedge clk); dat_re = 0;
    d = rd_data; v = rd_valid; ua = err_unaligned; rg = err_range;
  endtask

  task automatic frame(string tag, logic [47:0] dst, logic arp, logic exp);
    @(negedge clk); frm_valid = 1; frm_dst = dst; frm_arp = arp;
    @(negedge clk); frm_valid = 0; frm_arp = 0;
    chk({tag, " valid"}, 32'(dec_valid), 32'd1);
    chk(tag, 32'(dec_accept), 32'(exp));
  endtask

  task automatic t_reset;
    logic [15:0] d; logic v, ua, rg;
    chk("R1 dec_valid", 32'(dec_valid), 0);
    chk("R1 rd_valid", 32'(rd_valid), 0);
    chk("R1 errs", {29'b0, err_unaligned, err_range, err_unsupported}, 0);
    frame("R1 filter off at reset", 48'hFFFF_FFFF_FFFF, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      rdw(10'(2 * k), d, v, ua, rg);
      chk("R1 station zero", 32'(d), 0);
    end
  endtask

  task automatic t_station;
    logic [15:0] d; logic v, ua, rg;
    wr(10'h000, 16'h2211, ua, rg); wr(10'h002, 16'h4433, ua, rg);
    wr(10'h004, 16'h6655, ua, rg);
    chk("R2 no err", {30'b0, ua, rg}, 0);
    rdw(10'h000, d, v, ua, rg); chk("R2 word0", 32'(d), 32'h2211);
    chk("R12 rd_valid", 32'(v), 1);
    rdw(10'h002, d, v, ua, rg); chk("R2 word1", 32'(d), 32'h4433);
    rdw(10'h004, d, v, ua, rg); chk("R2 word2", 32'(d), 32'h6655);
  endtask

  task automatic t_hash;
    logic [15:0] d; logic v, ua, rg;
    for (int a = 0; a < 64; a += 2) begin
      hmodel[a] = 8'(a * 7 + 3); hmodel[a + 1] = 8'(a * 13 + 1);
      wr(10'(10'h200 + a), {hmodel[a + 1], hmodel[a]}, ua, rg);
      if (ua || rg) chk("R3 hash write err", {30'b0, ua, rg}, 0);
    end
    foreach (hmodel[a]) if (a % 10 == 0 || a == 62) begin
      rdw(10'(10'h200 + a), d, v, ua, rg);
      chk("R3 hash word", 32'(d), {16'b0, hmodel[a + 1], hmodel[a]});
    end
  endtask

  task automatic t_unaligned;
    logic [15:0] d; logic v, ua, rg;
    wr(10'h201, 16'hDEAD, ua, rg);
    chk("R4 write flag", {30'b0, ua, rg}, 32'b10);
    rdw(10'h200, d, v, ua, rg);
    chk("R4 no modify", 32'(d), {16'b0, hmodel[1], hmodel[0]});
    rdw(10'h23F, d, v, ua, rg);
    chk("R4 read flag", {30'b0, ua, rg}, 32'b10);
    chk("R4 read zero", 32'(d), 0);
  endtask

  task automatic t_range;
    logic [15:0] d; logic v, ua, rg;
    wr(10'h006, 16'hBEEF, ua, rg); chk("R5 0x006 flag", {30'b0, ua, rg}, 32'b01);
    wr(10'h240, 16'hBEEF, ua, rg); chk("R5 0x240 flag", {30'b0, ua, rg}, 32'b01);
    wr(10'h003, 16'hBEEF, ua, rg); chk("R5 0x003 flag", {30'b0, ua, rg}, 32'b01);
    rdw(10'h1FF, d, v, ua, rg);
    chk("R5 0x1FF flag", {30'b0, ua, rg}, 32'b01); chk("R5 read zero", 32'(d), 0);
    rdw(10'h004, d, v, ua, rg); chk("R5 station kept", 32'(d), 32'h6655);
    rdw(10'h002, d, v, ua, rg); chk("R5 station kept", 32'(d), 32'h4433);
    rdw(10'h23E, d, v, ua, rg);
    chk("R5 hash end kept", 32'(d), {16'b0, hmodel[63], hmodel[62]});
  endtask

  task automatic t_priority;
    set_ctl(32'h0000_0000);
    @(negedge clk); dat_we = 1; dat_re = 1; dat_wdata = 16'hA1B2;
    @(negedge clk); dat_we = 0; dat_re = 0;
    chk("R12 read ignored", 32'(rd_valid), 0);
    @(negedge clk); dat_re = 1;
    @(negedge clk); dat_re = 0;
    chk("R12 write done", 32'(rd_data), 32'hA1B2);
    @(negedge clk); dat_we = 1; dat_wdata = 16'h2211;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic t_classes;
    localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF, MC = 48'h0000_0000_0001,
      UC = 48'h0000_0000_0002, ST = 48'h6655_4433_2211;
    set_ctl(F_BC | F_MC | F_UC | F_PM | F_ARP | F_MH);
    frame("R6 off bcast", BC, 0, 0); frame("R6 off mcast", MC, 0, 0);
    frame("R6 off ucast", UC, 1, 0);
    set_ctl(F_EN | F_BC);
    frame("R7 bc bcast", BC, 0, 1); frame("R7 bc mcast", MC, 0, 0);
    frame("R7 bc ucast", UC, 0, 0);
    set_ctl(F_EN | F_MC);
    frame("R7 mc bcast", BC, 0, 0); frame("R7 mc mcast", MC, 0, 1);
    frame("R7 mc ucast", UC, 0, 0);
    set_ctl(F_EN | F_UC);
    frame("R7 uc bcast", BC, 0, 0); frame("R7 uc mcast", MC, 0, 0);
    frame("R7 uc ucast", UC, 0, 1);
    set_ctl(F_EN | F_PM);
    frame("R8 exact", ST, 0, 1); frame("R8 top byte", 48'h6755_4433_2211, 0, 0);
    frame("R8 low byte", 48'h6655_4433_2210, 0, 0);
    set_ctl(F_EN | F_ARP);
    frame("R9 arp", UC, 1, 1); frame("R9 not arp", UC, 0, 0);
    set_ctl(F_EN | F_MH);
    frame("R10 mcast", 48'h1234_5678_9AB3, 0, 1); frame("R10 ucast", UC, 0, 0);
    frame("R10 bcast", BC, 0, 0);
  endtask

  task automatic t_unsupported;
    set_ctl(F_EN | F_UH); chk("R11 uhash", 32'(err_unsupported), 1);
    set_ctl(F_EN);        chk("R11 clear", 32'(err_unsupported), 0);
    set_ctl(F_ULM);       chk("R11 ulm", 32'(err_unsupported), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset; t_station; t_hash; t_unaligned; t_range; t_priority;
    t_classes; t_unsupported;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule